// File: doc/BRIEF.md
# Dual-channel PWM-to-digital converter

This block turns the one-bit pulse-width stream produced by an external integrating sweep converter into a signed digital value, once per synchronization interval. An externally supplied sync pulse closes one interval and opens the next. Inside each interval the block runs a digital sawtooth that restarts every `SUB_LEN` clock cycles. This sawtooth is the master sweep for the external analog loop. Nominally `N_SUB` such sub-periods fill one interval.

Two saturating counters measure the cycles during which the stream is high and low. When the interval closes, a sequential restoring divider forms the ratio of their difference to their sum. It scales the result by `2**FRAC_W` and reports it with a sign flag and a one-cycle valid strobe.

A mode input, sampled at each sync, chooses how the counters are used. In one mode they accumulate across the whole interval. In the other mode only the last complete sub-period counts, which gives the faster response.

Top module: `pwm_dual_cnt_conv`

## Requirements
- R1: In the cycle after a sync cycle, `ramp_o` and `sub_o` read 0. Otherwise `ramp_o` rises by 1 each cycle and returns to 0 after the value `SUB_LEN-1`. Each time it returns to 0, `sub_o` rises by 1, and it stays at `N_SUB-1` once it gets there.
- R2: `mode_i` is sampled only in a sync cycle and governs the interval that follows: 0 means whole-interval accumulation, 1 means last-sub-period only. Changes between syncs have no effect on the result.
- R3: In accumulation mode, N1 is the number of cycles with `pwm_i`=1 and N2 the number with `pwm_i`=0. Both span the cycle after one sync through the next sync cycle inclusive.
- R4: In last-sub-period mode, N1 and N2 cover only the most recent complete sub-period, meaning the `SUB_LEN` cycles ending in a cycle where `ramp_o` = `SUB_LEN-1` (that cycle may be the sync cycle itself).
- R5: The magnitude of `result_o` is floor(2**FRAC_W·|N1−N2|/(N1+N2)). `result_o` is two's complement and negative when N1 < N2. `sign_o` is 1 exactly when N1 < N2.
- R6: N1 and N2 each saturate at 2**CW−1 and never wrap.
- R7: `valid_o` is a single-cycle pulse that rises exactly `CW+FRAC_W` clock edges after the edge that samples the sync. `result_o`, `sign_o` and `err_o` change only together with `valid_o` and hold otherwise.
- R8: If N1+N2 = 0, the result is 0, `sign_o` is 0 and `err_o` is 1. Otherwise `err_o` is 0.
- R9: During reset and after its release, `ramp_o`, `sub_o`, `valid_o`, `result_o`, `sign_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | One-cycle pulse marking the last cycle of an interval |
| pwm_i | input | 1 | PWM stream from the sweep converter |
| mode_i | input | 1 | 0 = whole interval, 1 = last complete sub-period |
| ramp_o | output | clog2(SUB_LEN) | Reference sawtooth value |
| sub_o | output | clog2(N_SUB) | Index of the current sub-period |
| valid_o | output | 1 | Result strobe |
| result_o | output | FRAC_W+2 | Signed scaled ratio |
| sign_o | output | 1 | 1 when the low count exceeds the high count |
| err_o | output | 1 | Zero-denominator flag |

## Verification
Two situations are hard to reach from the ports. The first is a zero denominator, which can only arise in last-sub-period mode when a sync arrives before any sub-period has closed. The stimulus reaches it by issuing a sync a few cycles after a realigning sync. The second is counter saturation, which needs an interval longer than the counter range. The bench withholds sync for several hundred cycles and picks a low count such that a wrapped counter would give a clearly different quotient. Every table vector also drives the inverse mode between syncs, so any leak of the mode input into the running interval changes the result.

// File: rtl/pwm_conv_pkg.sv
package pwm_conv_pkg;

  typedef enum logic {
    MODE_ALL  = 1'b0,
    MODE_LAST = 1'b1
  } conv_mode_e;

  // Width needed to index n values, never below one bit.
  function automatic int unsigned bits_for(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pwm_ramp_gen.sv
module pwm_ramp_gen
  import pwm_conv_pkg::*;
#(
  parameter int unsigned SUB_LEN = 256,
  parameter int unsigned N_SUB   = 4,
  localparam int unsigned RAMP_W = bits_for(SUB_LEN),
  localparam int unsigned SUB_W  = bits_for(N_SUB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              sub_last_o
);

  localparam logic [RAMP_W-1:0] RAMP_MAX = RAMP_W'(SUB_LEN - 1);
  localparam logic [SUB_W-1:0]  SUB_MAX  = SUB_W'(N_SUB - 1);

  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              at_top;

  assign at_top = (ramp_q == RAMP_MAX);

  always_comb begin
    ramp_d = ramp_q;
    sub_d  = sub_q;
    if (sync_i) begin
      ramp_d = '0;
      sub_d  = '0;
    end else if (at_top) begin
      ramp_d = '0;
      sub_d  = (sub_q == SUB_MAX) ? sub_q : SUB_W'(sub_q + 1'b1);
    end else begin
      ramp_d = RAMP_W'(ramp_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
      sub_q  <= '0;
    end else begin
      ramp_q <= ramp_d;
      sub_q  <= sub_d;
    end
  end

  assign ramp_o     = ramp_q;
  assign sub_o      = sub_q;
  assign sub_last_o = at_top;

endmodule

// File: rtl/pwm_duty_cnt.sv
module pwm_duty_cnt
  import pwm_conv_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          pwm_i,
  input  logic          mode_i,
  input  logic          sub_last_i,
  output logic [CW-1:0] hi_o,
  output logic [CW-1:0] lo_o
);

  conv_mode_e    mode_q, mode_d;
  logic [CW-1:0] cnt_hi_q, cnt_hi_d, cnt_lo_q, cnt_lo_d;
  logic [CW-1:0] snap_hi_q, snap_hi_d, snap_lo_q, snap_lo_d;
  logic [CW-1:0] end_hi, end_lo;
  logic          last_mode, close_sub;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v, input logic en);
    return (en && (v != '1)) ? CW'(v + 1'b1) : v;
  endfunction

  assign last_mode = (mode_q == MODE_LAST);
  assign close_sub = last_mode && sub_last_i;
  assign end_hi    = sat_inc(cnt_hi_q, pwm_i);
  assign end_lo    = sat_inc(cnt_lo_q, !pwm_i);

  always_comb begin
    mode_d    = sync_i ? conv_mode_e'(mode_i) : mode_q;
    cnt_hi_d  = (sync_i || close_sub) ? '0 : end_hi;
    cnt_lo_d  = (sync_i || close_sub) ? '0 : end_lo;
    snap_hi_d = snap_hi_q;
    snap_lo_d = snap_lo_q;
    if (sync_i) begin
      snap_hi_d = '0;
      snap_lo_d = '0;
    end else if (close_sub) begin
      snap_hi_d = end_hi;
      snap_lo_d = end_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_ALL;
      cnt_hi_q  <= '0;
      cnt_lo_q  <= '0;
      snap_hi_q <= '0;
      snap_lo_q <= '0;
    end else begin
      mode_q    <= mode_d;
      cnt_hi_q  <= cnt_hi_d;
      cnt_lo_q  <= cnt_lo_d;
      snap_hi_q <= snap_hi_d;
      snap_lo_q <= snap_lo_d;
    end
  end

  // Operands presented in the sync cycle.
  assign hi_o = last_mode ? (sub_last_i ? end_hi : snap_hi_q) : end_hi;
  assign lo_o = last_mode ? (sub_last_i ? end_lo : snap_lo_q) : end_lo;

endmodule

// File: rtl/pwm_ratio_div.sv
module pwm_ratio_div #(
  parameter int unsigned CW     = 16,
  parameter int unsigned FRAC_W = 12,
  localparam int unsigned RW    = FRAC_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  output logic          valid_o,
  output logic [RW-1:0] result_o,
  output logic          sign_o,
  output logic          err_o
);

  localparam int unsigned NW     = CW + FRAC_W;
  localparam int unsigned STEP_W = $clog2(NW + 1);
  localparam logic [STEP_W-1:0] STEP_END = STEP_W'(NW - 1);

  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [NW-1:0]     num_q, num_d, quo_q, quo_d;
  logic [CW:0]       rem_q, rem_d, den_q, den_d;
  logic              neg_q, neg_d, zero_q, zero_d;
  logic              valid_q, valid_d, sign_q, sign_d, err_q, err_d;
  logic [RW-1:0]     res_q, res_d;
  logic [CW+1:0]     trial, trial_sub;
  logic [CW:0]       den_in;
  logic [CW-1:0]     diff_in;
  logic [RW-1:0]     mag;
  logic              qbit;

  always_comb begin
    den_in    = {1'b0, hi_i} + {1'b0, lo_i};
    diff_in   = (lo_i > hi_i) ? CW'(lo_i - hi_i) : CW'(hi_i - lo_i);
    trial     = {rem_q, num_q[NW-1]};
    trial_sub = trial - {1'b0, den_q};
    qbit      = (trial >= {1'b0, den_q});

    busy_d  = busy_q;
    step_d  = step_q;
    num_d   = num_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    den_d   = den_q;
    neg_d   = neg_q;
    zero_d  = zero_q;
    res_d   = res_q;
    sign_d  = sign_q;
    err_d   = err_q;
    valid_d = 1'b0;
    mag     = '0;

    if (start_i) begin
      busy_d = 1'b1;
      step_d = '0;
      num_d  = {diff_in, {FRAC_W{1'b0}}};
      quo_d  = '0;
      rem_d  = '0;
      den_d  = den_in;
      neg_d  = (lo_i > hi_i);
      zero_d = (den_in == '0);
    end else if (busy_q) begin
      rem_d = qbit ? trial_sub[CW:0] : trial[CW:0];
      num_d = {num_q[NW-2:0], 1'b0};
      quo_d = {quo_q[NW-2:0], qbit};
      if (step_q == STEP_END) begin
        busy_d  = 1'b0;
        valid_d = 1'b1;
        mag     = {1'b0, quo_d[FRAC_W:0]};
        res_d   = zero_q ? '0 : (neg_q ? RW'(-mag) : mag);
        sign_d  = !zero_q && neg_q;
        err_d   = zero_q;
      end else begin
        step_d = STEP_W'(step_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      num_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      neg_q   <= 1'b0;
      zero_q  <= 1'b0;
      res_q   <= '0;
      sign_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      step_q  <= step_d;
      num_q   <= num_d;
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      den_q   <= den_d;
      neg_q   <= neg_d;
      zero_q  <= zero_d;
      res_q   <= res_d;
      sign_q  <= sign_d;
      err_q   <= err_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;
  assign sign_o   = sign_q;
  assign err_o    = err_q;

endmodule

// File: rtl/pwm_dual_cnt_conv.sv
module pwm_dual_cnt_conv
  import pwm_conv_pkg::*;
#(
  parameter int unsigned CW      = 16,
  parameter int unsigned FRAC_W  = 12,
  parameter int unsigned SUB_LEN = 256,
  parameter int unsigned N_SUB   = 4,
  localparam int unsigned RAMP_W = bits_for(SUB_LEN),
  localparam int unsigned SUB_W  = bits_for(N_SUB),
  localparam int unsigned RW     = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_i,
  input  logic              pwm_i,
  input  logic              mode_i,
  output logic [RAMP_W-1:0] ramp_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              valid_o,
  output logic [RW-1:0]     result_o,
  output logic              sign_o,
  output logic              err_o
);

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic          sub_last;
  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  pwm_ramp_gen #(
    .SUB_LEN(SUB_LEN),
    .N_SUB  (N_SUB)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sync_i    (sync_i),
    .ramp_o    (ramp_o),
    .sub_o     (sub_o),
    .sub_last_o(sub_last)
  );

  pwm_duty_cnt #(
    .CW(CW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sync_i    (sync_i),
    .pwm_i     (pwm_i),
    .mode_i    (mode_i),
    .sub_last_i(sub_last),
    .hi_o      (hi_cnt),
    .lo_o      (lo_cnt)
  );

  pwm_ratio_div #(
    .CW    (CW),
    .FRAC_W(FRAC_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (sync_i),
    .hi_i    (hi_cnt),
    .lo_i    (lo_cnt),
    .valid_o (valid_o),
    .result_o(result_o),
    .sign_o  (sign_o),
    .err_o   (err_o)
  );

endmodule

// File: rtl/pwm_dual_cnt_conv_chk.sv
module pwm_dual_cnt_conv_chk
  import pwm_conv_pkg::*;
#(
  parameter int unsigned SUB_LEN = 256,
  parameter int unsigned N_SUB   = 4,
  parameter int unsigned RW      = 14,
  localparam int unsigned RAMP_W = bits_for(SUB_LEN),
  localparam int unsigned SUB_W  = bits_for(N_SUB)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic [RAMP_W-1:0] ramp_o,
  input logic [SUB_W-1:0]  sub_o,
  input logic              valid_o,
  input logic [RW-1:0]     result_o,
  input logic              sign_o,
  input logic              err_o
);

  localparam logic [RAMP_W-1:0] RAMP_MAX = RAMP_W'(SUB_LEN - 1);
  localparam logic [SUB_W-1:0]  SUB_MAX  = SUB_W'(N_SUB - 1);

  assert_sync_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (ramp_o == '0 && sub_o == '0));

  assert_ramp_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && ramp_o != RAMP_MAX) |=> (ramp_o == RAMP_W'($past(ramp_o) + 1'b1)));

  assert_ramp_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_i && ramp_o == RAMP_MAX) |=> (ramp_o == '0));

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sub_o <= SUB_MAX);

  assert_neg_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && result_o[RW-1]) |-> sign_o);

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(result_o) && $stable(sign_o) && $stable(err_o)));

  assert_zero_den_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && err_o) |-> (result_o == '0 && !sign_o));

endmodule

bind pwm_dual_cnt_conv pwm_dual_cnt_conv_chk #(
  .SUB_LEN(SUB_LEN),
  .N_SUB  (N_SUB),
  .RW     (RW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sync_i  (sync_i),
  .ramp_o  (ramp_o),
  .sub_o   (sub_o),
  .valid_o (valid_o),
  .result_o(result_o),
  .sign_o  (sign_o),
  .err_o   (err_o)
);

// File: tb/tb_pwm_dual_cnt_conv.sv
module tb_pwm_dual_cnt_conv;

  localparam int CW      = 8;
  localparam int FRAC_W  = 6;
  localparam int SUB_LEN = 16;
  localparam int N_SUB   = 4;
  localparam int RW      = FRAC_W + 2;
  localparam int LAT     = CW + FRAC_W + 1;  // negedges after the sync edge

  // {mode, h0, h1, h2, h3, expected result}: hN = high cycles at the start of sub-period N
  localparam logic [28:0] VEC [8] = '{
    {1'b0, 5'd8,  5'd8,  5'd8,  5'd8,  8'h00},
    {1'b0, 5'd12, 5'd12, 5'd12, 5'd12, 8'h20},
    {1'b0, 5'd2,  5'd4,  5'd6,  5'd8,  8'hE8},
    {1'b1, 5'd2,  5'd4,  5'd6,  5'd12, 8'h20},
    {1'b1, 5'd16, 5'd16, 5'd16, 5'd3,  8'hD8},
    {1'b0, 5'd16, 5'd16, 5'd16, 5'd16, 8'h40},
    {1'b0, 5'd5,  5'd0,  5'd0,  5'd0,  8'hCA},
    {1'b1, 5'd0,  5'd0,  5'd0,  5'd9,  8'h08}
  };

  logic          clk, rst_n, sync_i, pwm_i, mode_i;
  logic [3:0]    ramp_o;
  logic [1:0]    sub_o;
  logic          valid_o, sign_o, err_o;
  logic [RW-1:0] result_o;

  int  total, bad;
  bit  done;

  pwm_dual_cnt_conv #(
    .CW(CW), .FRAC_W(FRAC_W), .SUB_LEN(SUB_LEN), .N_SUB(N_SUB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .pwm_i(pwm_i), .mode_i(mode_i),
    .ramp_o(ramp_o), .sub_o(sub_o), .valid_o(valid_o), .result_o(result_o),
    .sign_o(sign_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs for one cycle and returns at the next negedge.
  task automatic drive(input bit s, input bit p, input bit m);
    sync_i = s;
    pwm_i  = p;
    mode_i = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_valid(output int lat);
    lat = 1;
    while (!valid_o && lat < 100) begin
      drive(1'b0, 1'b0, 1'b0);
      lat++;
    end
  endtask

  task automatic run_vector(input int idx);
    bit mode;
    int h [4];
    int lat, exp_res;
    mode    = VEC[idx][28];
    h[0]    = int'(VEC[idx][27:23]);
    h[1]    = int'(VEC[idx][22:18]);
    h[2]    = int'(VEC[idx][17:13]);
    h[3]    = int'(VEC[idx][12:8]);
    exp_res = int'($signed(VEC[idx][7:0]));
    drive(1'b1, 1'b0, mode);  // realign sync, latches the mode
    for (int c = 0; c < N_SUB * SUB_LEN; c++) begin
      // mode_i is inverted between syncs: R2 says it must be ignored
      drive(c == N_SUB * SUB_LEN - 1, (c % SUB_LEN) < h[c / SUB_LEN],
            (c == N_SUB * SUB_LEN - 1) ? mode : !mode);
    end
    wait_valid(lat);
    check(valid_o == 1'b1, $sformatf("R7 valid seen vec%0d", idx), int'(valid_o), 1);
    if (idx == 0) check(lat == LAT, "R7 latency", lat, LAT);
    check(int'($signed(result_o)) == exp_res,
          $sformatf("R3/R4/R5/R2 result vec%0d", idx), int'($signed(result_o)), exp_res);
    check(sign_o == (exp_res < 0), $sformatf("R5 sign vec%0d", idx), int'(sign_o), int'(exp_res < 0));
    check(err_o == 1'b0, $sformatf("R8 no error vec%0d", idx), int'(err_o), 0);
  endtask

  initial begin
    int lat;
    logic [RW-1:0] held;
    total  = 0;
    bad    = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    sync_i = 1'b0;
    pwm_i  = 1'b0;
    mode_i = 1'b0;
    repeat (3) @(negedge clk);
    check(ramp_o == '0 && sub_o == '0, "R9 ramp in reset", int'(ramp_o), 0);
    check(valid_o == 1'b0 && err_o == 1'b0, "R9 strobes in reset", int'(valid_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(result_o == '0 && sign_o == 1'b0, "R9 result after reset", int'(result_o), 0);

    // Table-driven vectors
    for (int i = 0; i < 8; i++) begin
      run_vector(i);
      if (i == 0) begin
        drive(1'b0, 1'b0, 1'b0);
        check(valid_o == 1'b0, "R7 strobe is one cycle", int'(valid_o), 0);
        held = result_o;
        repeat (5) drive(1'b0, 1'b1, 1'b1);
        check(result_o == held, "R7 result holds", int'(result_o), int'(held));
      end
    end

    // R6 saturation with R1 ramp and sub-period checks: 20 low, 300 high, accumulation mode
    drive(1'b1, 1'b0, 1'b0);
    check(ramp_o == '0 && sub_o == '0, "R1 restart after sync", int'(ramp_o), 0);
    for (int c = 0; c < 320; c++) begin
      if (c == 20) begin
        check(ramp_o == 4'd4, "R1 ramp at cycle 20", int'(ramp_o), 4);
        check(sub_o == 2'd1, "R1 sub at cycle 20", int'(sub_o), 1);
      end
      if (c == 100) begin
        check(ramp_o == 4'd4, "R1 ramp at cycle 100", int'(ramp_o), 4);
        check(sub_o == 2'd3, "R1 sub saturates", int'(sub_o), 3);
      end
      drive(c == 319, c >= 20, 1'b1);
    end
    wait_valid(lat);
    // N1 = 255 (saturated), N2 = 20: floor(64*235/275) = 54
    check(int'($signed(result_o)) == 54, "R6 saturating count", int'($signed(result_o)), 54);
    check(sign_o == 1'b0, "R6 sign", int'(sign_o), 0);

    // R8 zero denominator: last-sub mode, sync before any sub-period closes
    drive(1'b1, 1'b0, 1'b1);
    for (int c = 0; c < 5; c++) drive(c == 4, 1'b1, 1'b1);
    wait_valid(lat);
    check(err_o == 1'b1, "R8 error flag", int'(err_o), 1);
    check(result_o == '0 && sign_o == 1'b0, "R8 zero result", int'(result_o), 0);

    // R8 error clears on the next good result: two back-to-back syncs, accumulation
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);  // N1=0, N2=1 -> -64
    wait_valid(lat);
    check(err_o == 1'b0, "R8 error clears", int'(err_o), 0);
    check(int'($signed(result_o)) == -64, "R5 full-scale negative", int'($signed(result_o)), -64);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule